// File: doc/BRIEF.md
# Two-Stage Baud Divider with Serial Transmitter

This block derives serial timing from the system clock and sends characters on an asynchronous line. A first divider stage with one of four factors (1, 3, 4 or 13) feeds a second stage that divides by a power of two from 1 to 128. The output of the second stage is a one-cycle sample tick at sixteen times the bit rate, offered to a companion receiver. A further divide by sixteen gives the internal bit tick that times the transmitter. With a 2 MHz clock, a first factor of 13 and a second factor of 1, the bit rate comes out close to 9600.

Software places a character in a one-deep holding register with a write strobe. At the next bit tick boundary the transmitter moves it into its shifter and sends a low start bit, 8 or 9 data bits least significant first, and a high stop bit. Two flags report progress: the holding register is empty, and the line has gone quiet with nothing left to send. Each flag has its own interrupt enable. A transmit enable gates the start of new frames, and a break request holds the line low for whole frame times until it is withdrawn.

Top module: `async_tx_rategen`

## Requirements
- R1: The first divider factor follows `pre_sel`: 00 gives 1, 01 gives 3, 10 gives 4, 11 gives 13.
- R2: `sample_tick` repeats every P * 2^`rate_sel` clock cycles, with P the first factor. When that product exceeds 1, each pulse lasts a single cycle.
- R3: One transmitted bit lasts 16 sample tick periods, and `txd` changes only on a bit tick boundary.
- R4: With `nine_mode` = 0 a frame is one bit of 0, then the 8 bits of `wr_data` with bit 0 first, then one bit of 1.
- R5: With `nine_mode` = 1 the frame carries 9 data bits. The ninth goes out last, after `wr_data[7]`, and is the value of `wr_bit8` captured with the write.
- R6: After reset `txd` = 1, `tx_empty` = 1 and `tx_done` = 1. A write clears `tx_empty`. It sets again on the bit tick where the character enters the shifter, and that same boundary starts the start bit.
- R7: A write clears `tx_done`, and so does the start of a break. `tx_done` sets when a frame or post-break bit ends with the holding register empty. While `tx_done` = 1 the line is high.
- R8: A character written while the previous one is still shifting starts right after that stop bit, with no idle bit between the frames.
- R9: With `tx_en` = 0 no frame starts, the line stays high and a written character stays pending. A frame already in progress completes.
- R10: While `brk_en` and `tx_en` are both 1, the line is held low in whole frame lengths without a break between them. A pending character waits for the break to end.
- R11: When a break is withdrawn, the line is high for at least one bit time before the next start bit.
- R12: `irq` is 1 exactly when (`tx_empty` and `ie_empty`) or (`tx_done` and `ie_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_sel | input | 2 | First divider stage factor code |
| rate_sel | input | 3 | Second divider stage exponent |
| tx_en | input | 1 | Allows new frames to start |
| brk_en | input | 1 | Requests a continuous break |
| nine_mode | input | 1 | 1 selects 9 data bits per frame |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| wr_bit8 | input | 1 | Ninth data bit, captured with the write |
| ie_empty | input | 1 | Interrupt enable for the holding-register-empty flag |
| ie_done | input | 1 | Interrupt enable for the transmission-complete flag |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete and nothing pending |
| sample_tick | output | 1 | Pulse at 16 times the bit rate |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 3-bit second-stage code and sixteen samples per bit. That puts every first-stage factor and every power of two up to 128 within reach, including the slowest setting of 1664 cycles per sample tick. Most frames run at the fastest rate, 16 cycles per bit. At that rate, back-to-back frames, nine-bit frames, several frame lengths of break and the single high bit after a break all fit in a short run. One frame at a 96-cycle bit shows that the bit timing follows the divider settings.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    // Factor of the first divider stage for each 2-bit code
    function automatic logic [3:0] prescale_factor(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd1;
            2'b01:   return 4'd3;
            2'b10:   return 4'd4;
            default: return 4'd13;
        endcase
    endfunction

    // What the shifter is currently producing on the line
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_CHAR  = 2'd1,
        FR_BREAK = 2'd2,
        FR_GAP   = 2'd3
    } frame_kind_e;

endpackage

// File: rtl/async_tx_rate_gen.sv
module async_tx_rate_gen
    import async_tx_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pre_sel,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             sample_tick,
    output logic             bit_tick
);
    localparam int PRE_CNT_W = 4;
    localparam int DIV_W     = (1 << SEL_W) - 1;
    localparam int OVS_W     = $clog2(OVS);

    typedef struct packed {
        logic [PRE_CNT_W-1:0] pre_cnt;
        logic [DIV_W-1:0]     div_cnt;
        logic [OVS_W-1:0]     ovs_cnt;
        logic                 samp;
        logic                 bitp;
    } rate_state_t;

    rate_state_t st_d, st_q;

    logic [PRE_CNT_W-1:0] pre_lim;
    logic [DIV_W-1:0]     div_lim;
    logic                 pre_hit;
    logic                 div_hit;

    always_comb begin
        pre_lim = prescale_factor(pre_sel) - 4'd1;
        div_lim = DIV_W'((32'd1 << rate_sel) - 32'd1);
        // A code change can leave a counter above its new limit: wrap then too
        pre_hit = (st_q.pre_cnt >= pre_lim);
        div_hit = (st_q.div_cnt >= div_lim);

        st_d      = st_q;
        st_d.samp = 1'b0;
        st_d.bitp = 1'b0;
        if (pre_hit) begin
            st_d.pre_cnt = '0;
            if (div_hit) begin
                st_d.div_cnt = '0;
                st_d.samp    = 1'b1;
                if (st_q.ovs_cnt == OVS_W'(OVS - 1)) begin
                    st_d.ovs_cnt = '0;
                    st_d.bitp    = 1'b1;
                end else begin
                    st_d.ovs_cnt = st_q.ovs_cnt + 1'b1;
                end
            end else begin
                st_d.div_cnt = st_q.div_cnt + 1'b1;
            end
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_tick = st_q.samp;
    assign bit_tick    = st_q.bitp;

endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_en,
    input  logic              nine_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done
);
    localparam int SH_W  = DATA_W + 2;
    localparam int CNT_W = $clog2(DATA_W + 3);

    typedef struct packed {
        frame_kind_e       kind;
        logic              txd;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] hold;
        logic              hold_b8;
        logic              full;
        logic              done;
    } tx_state_t;

    localparam tx_state_t RESET_ST = '{
        kind:    FR_IDLE,
        txd:     1'b1,
        cnt:     '0,
        sh:      '1,
        hold:    '0,
        hold_b8: 1'b0,
        full:    1'b0,
        done:    1'b1
    };

    tx_state_t st_d, st_q;

    logic [CNT_W-1:0] frame_cnt;
    logic             shifting;
    logic             brk_req;

    always_comb begin
        // Bits that follow the start bit: data plus stop
        frame_cnt = nine_mode ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
        shifting  = ((st_q.kind == FR_CHAR) || (st_q.kind == FR_BREAK))
                    && (st_q.cnt != '0);
        brk_req   = brk_en && tx_en;

        st_d = st_q;
        if (bit_tick) begin
            if (shifting) begin
                st_d.txd = st_q.sh[0];
                st_d.sh  = {1'b1, st_q.sh[SH_W-1:1]};
                st_d.cnt = st_q.cnt - 1'b1;
            end else if ((st_q.kind == FR_BREAK) && !brk_req) begin
                // Break withdrawn: one full high bit before anything else
                st_d.kind = FR_GAP;
                st_d.txd  = 1'b1;
                st_d.cnt  = '0;
            end else if (brk_req) begin
                st_d.kind = FR_BREAK;
                st_d.txd  = 1'b0;
                st_d.sh   = '0;
                st_d.cnt  = frame_cnt;
                st_d.done = 1'b0;
            end else if (tx_en && st_q.full) begin
                st_d.kind = FR_CHAR;
                st_d.txd  = 1'b0;
                st_d.sh   = {1'b1, (nine_mode ? st_q.hold_b8 : 1'b1), st_q.hold};
                st_d.cnt  = frame_cnt;
                st_d.full = 1'b0;
            end else begin
                if ((st_q.kind != FR_IDLE) && !st_q.full) begin
                    st_d.done = 1'b1;
                end
                st_d.kind = FR_IDLE;
                st_d.txd  = 1'b1;
            end
        end

        // A write after a load in the same cycle becomes the next pending one
        if (wr_stb) begin
            st_d.hold    = wr_data;
            st_d.hold_b8 = wr_bit8;
            st_d.full    = 1'b1;
            st_d.done    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd      = st_q.txd;
    assign tx_empty = !st_q.full;
    assign tx_done  = st_q.done;

endmodule

// File: rtl/async_tx_rategen.sv
module async_tx_rategen
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pre_sel,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic              tx_en,
    input  logic              brk_en,
    input  logic              nine_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    input  logic              ie_empty,
    input  logic              ie_done,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done,
    output logic              sample_tick,
    output logic              irq
);
    logic bit_tick;

    async_tx_rate_gen #(
        .SEL_W (SEL_W),
        .OVS   (OVS)
    ) i_rate_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_sel     (pre_sel),
        .rate_sel    (rate_sel),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    async_tx_shifter #(
        .DATA_W (DATA_W)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .brk_en    (brk_en),
        .nine_mode (nine_mode),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_bit8   (wr_bit8),
        .txd       (txd),
        .tx_empty  (tx_empty),
        .tx_done   (tx_done)
    );

    assign irq = (tx_empty && ie_empty) || (tx_done && ie_done);

endmodule

// File: rtl/async_tx_rategen_chk.sv
module async_tx_rategen_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic wr_stb,
    input logic txd,
    input logic tx_empty,
    input logic tx_done
);
    // R3: the line moves only on the edge that follows a bit tick
    assert_line_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(bit_tick));

    // R6: the holding register empties only on a bit tick boundary
    assert_load_on_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(bit_tick));

    // R6: a load puts the start bit on the line at once
    assert_load_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> !txd);

    // R7: a write clears the complete flag
    assert_write_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !tx_done);

    // R7: complete means the line is idle high
    assert_done_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

    // R7: complete never rises while a character is pending
    assert_done_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_empty);

endmodule

bind async_tx_rategen async_tx_rategen_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .wr_stb   (wr_stb),
    .txd      (txd),
    .tx_empty (tx_empty),
    .tx_done  (tx_done)
);

// File: tb/test_async_tx_rategen.sv
module test_async_tx_rategen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pre_sel = 2'b00;
    logic [2:0] rate_sel = 3'b000;
    logic       tx_en = 1'b0;
    logic       brk_en = 1'b0;
    logic       nine_mode = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit8 = 1'b0;
    logic       ie_empty = 1'b0;
    logic       ie_done = 1'b0;
    logic       txd, tx_empty, tx_done, sample_tick, irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  run_over = 0;
    logic st_empty, st_done;

    always #2 clk = ~clk;

    async_tx_rategen i_async_tx_rategen (
        .clk (clk), .rst_n (rst_n), .pre_sel (pre_sel), .rate_sel (rate_sel),
        .tx_en (tx_en), .brk_en (brk_en), .nine_mode (nine_mode),
        .wr_stb (wr_stb), .wr_data (wr_data), .wr_bit8 (wr_bit8),
        .ie_empty (ie_empty), .ie_done (ie_done),
        .txd (txd), .tx_empty (tx_empty), .tx_done (tx_done),
        .sample_tick (sample_tick), .irq (irq)
    );

    function automatic int exp_prescale(input logic [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b01:   return 3;
            2'b10:   return 4;
            default: return 13;
        endcase
    endfunction

    function automatic int exp_period(input logic [1:0] p, input logic [2:0] s);
        return exp_prescale(p) * (1 << s);
    endfunction

    function automatic bit exp_irq(input bit e, input bit d, input bit ie, input bit id);
        return (e && ie) || (d && id);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!run_over) begin
            run_over = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b8);
        wr_data = d;
        wr_bit8 = b8;
        wr_stb  = 1'b1;
        tick(1);
        wr_stb  = 1'b0;
    endtask

    // mode 0: wait for a start bit; mode 1: start just seen;
    // mode 2: at mid stop bit of the previous frame, next start expected at once
    task automatic decode(input int mode, input int nb, input int bt,
                          output logic [8:0] d, output bit ok);
        int w;
        ok = 1;
        d  = '0;
        if (mode == 2) tick(bt / 2);
        if (mode == 0) begin
            w = 0;
            while (txd !== 1'b0 && w < bt * 40) begin
                tick(1);
                w++;
            end
        end
        if (txd !== 1'b0) ok = 0;
        st_empty = tx_empty;
        st_done  = tx_done;
        tick(bt / 2);
        if (txd !== 1'b0) ok = 0;
        for (int i = 0; i < nb; i++) begin
            tick(bt);
            d[i] = txd;
        end
        tick(bt);
        if (txd !== 1'b1) ok = 0;
    endtask

    task automatic measure(output int per, output bit narrow);
        int n;
        n = 0;
        while (sample_tick !== 1'b1 && n < 4000) begin tick(1); n++; end
        tick(1);
        narrow = (sample_tick === 1'b0);
        per = 1;
        while (sample_tick !== 1'b1 && per < 4000) begin tick(1); per++; end
    endtask

    task automatic rate_case(input logic [1:0] p, input logic [2:0] s);
        int per, e;
        bit nar;
        pre_sel  = p;
        rate_sel = s;
        measure(per, nar);
        measure(per, nar);
        e = exp_period(p, s);
        check(per == e, (s == 0) ? "R1" : "R2", "sample period", per, e);
        if (e > 1) check(nar, "R2", "sample pulse width one cycle", nar, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", 200000, 0);
        finish_run();
    end

    initial begin
        logic [8:0] got;
        logic [7:0] c1, c2;
        logic       b8;
        bit         ok;
        int         lows, highs, w;

        void'($urandom(32'h5A17C3));
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // Reset state
        check(txd === 1'b1, "R6", "txd after reset", txd, 1);
        check(tx_empty === 1'b1, "R6", "empty after reset", tx_empty, 1);
        check(tx_done === 1'b1, "R7", "done after reset", tx_done, 1);
        check(irq === 1'b0, "R12", "irq with enables off", irq, 0);

        // Divider: every first-stage code, every exponent, random pairs
        for (int p = 0; p < 4; p++) rate_case(2'(p), 3'd0);
        for (int s = 1; s < 8; s++) rate_case(2'b00, 3'(s));
        rate_case(2'b11, 3'd7);
        for (int k = 0; k < 4; k++) rate_case(2'($urandom_range(3)), 3'($urandom_range(5)));

        // Fastest rate: 16 cycles per bit
        pre_sel  = 2'b00;
        rate_sel = 3'd0;
        tx_en    = 1'b1;
        tick(40);

        // First character: flag sequence around the load
        c1 = 8'hA5;
        send(c1, 1'b0);
        check(tx_empty === 1'b0, "R6", "empty cleared by write", tx_empty, 0);
        check(tx_done === 1'b0, "R7", "done cleared by write", tx_done, 0);
        decode(0, 8, 16, got, ok);
        check(st_empty === 1'b1, "R6", "empty set at start bit", st_empty, 1);
        check(st_done === 1'b0, "R7", "done low while sending", st_done, 0);
        check(ok && got[7:0] == c1, "R4", "8-bit frame", got[7:0], c1);
        tick(16);
        check(tx_done === 1'b1 && txd === 1'b1, "R7", "done after last stop", tx_done, 1);

        // Random 8-bit characters
        for (int k = 0; k < 6; k++) begin
            c1 = 8'($urandom_range(255));
            send(c1, 1'($urandom_range(1)));
            decode(0, 8, 16, got, ok);
            check(ok && got[7:0] == c1, "R4", "random 8-bit frame", got[7:0], c1);
        end

        // Slower setting: factor 3 times 2 gives 96 cycles per bit
        pre_sel  = 2'b01;
        rate_sel = 3'd1;
        tick(200);
        c1 = 8'h3C;
        send(c1, 1'b0);
        decode(0, 8, 96, got, ok);
        check(ok && got[7:0] == c1, "R3", "frame at 96-cycle bit", got[7:0], c1);
        pre_sel  = 2'b00;
        rate_sel = 3'd0;
        tick(200);

        // Nine data bits, ninth from the write
        nine_mode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            c1 = 8'($urandom_range(255));
            b8 = (k == 0) ? 1'b0 : (k == 1) ? 1'b1 : 1'($urandom_range(1));
            send(c1, b8);
            decode(0, 9, 16, got, ok);
            check(ok && got == {b8, c1}, "R5", "9-bit frame", got, {b8, c1});
        end
        nine_mode = 1'b0;
        tick(20);

        // Back-to-back frames
        c1 = 8'h81;
        c2 = 8'h7E;
        send(c1, 1'b0);
        w = 0;
        while (tx_empty !== 1'b1 && w < 100) begin tick(1); w++; end
        send(c2, 1'b0);
        decode(1, 8, 16, got, ok);
        check(ok && got[7:0] == c1, "R8", "first of pair", got[7:0], c1);
        decode(2, 8, 16, got, ok);
        check(ok && got[7:0] == c2, "R8", "second of pair without gap", got[7:0], c2);
        tick(40);

        // Transmit disabled: pending character waits, line high
        tx_en = 1'b0;
        c1 = 8'hC3;
        send(c1, 1'b0);
        lows = 0;
        for (int i = 0; i < 800; i++) begin
            tick(1);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R9", "line low cycles while disabled", lows, 0);
        check(tx_empty === 1'b0, "R9", "character kept while disabled", tx_empty, 0);
        tx_en = 1'b1;
        decode(0, 8, 16, got, ok);
        check(ok && got[7:0] == c1, "R9", "pending sent after enable", got[7:0], c1);

        // Disable in mid frame: the frame completes
        c1 = 8'h96;
        send(c1, 1'b0);
        w = 0;
        while (txd !== 1'b0 && w < 100) begin tick(1); w++; end
        tx_en = 1'b0;
        decode(1, 8, 16, got, ok);
        check(ok && got[7:0] == c1, "R9", "frame finishes after disable", got[7:0], c1);
        tx_en = 1'b1;
        tick(40);

        // Break: continuous low, pending character held back
        brk_en = 1'b1;
        w = 0;
        while (txd !== 1'b0 && w < 100) begin tick(1); w++; end
        tick(1);
        check(tx_done === 1'b0, "R7", "done cleared by break", tx_done, 0);
        highs = 0;
        for (int i = 0; i < 480; i++) begin
            tick(1);
            if (txd !== 1'b0) highs++;
        end
        check(highs == 0, "R10", "high cycles in three break frames", highs, 0);
        c1 = 8'h5A;
        send(c1, 1'b0);
        highs = 0;
        for (int i = 0; i < 320; i++) begin
            tick(1);
            if (txd !== 1'b0) highs++;
        end
        check(highs == 0 && tx_empty === 1'b0, "R10", "break holds over pending", highs, 0);
        brk_en = 1'b0;
        w = 0;
        while (txd !== 1'b1 && w < 400) begin tick(1); w++; end
        highs = 0;
        while (txd !== 1'b0 && highs < 800) begin tick(1); highs++; end
        check(highs >= 16 && highs <= 32, "R11", "high cycles after break", highs, 16);
        decode(1, 8, 16, got, ok);
        check(ok && got[7:0] == c1, "R11", "character after break", got[7:0], c1);
        tick(20);

        // Interrupt combinations
        for (int k = 0; k < 4; k++) begin
            ie_empty = k[0];
            ie_done  = k[1];
            tick(1);
            check(irq === exp_irq(tx_empty, tx_done, ie_empty, ie_done), "R12",
                  "irq at idle", irq, exp_irq(1, 1, ie_empty, ie_done));
        end
        tx_en = 1'b0;
        send(8'h11, 1'b0);
        for (int k = 0; k < 4; k++) begin
            ie_empty = k[0];
            ie_done  = k[1];
            tick(1);
            check(irq === exp_irq(0, 0, ie_empty, ie_done), "R12",
                  "irq with character pending", irq, 0);
        end
        tx_en = 1'b1;
        w = 0;
        while (txd !== 1'b0 && w < 100) begin tick(1); w++; end
        ie_empty = 1'b0;
        ie_done  = 1'b1;
        tick(1);
        check(irq === 1'b0, "R12", "done enable while shifting", irq, 0);
        ie_empty = 1'b1;
        ie_done  = 1'b0;
        tick(1);
        check(irq === 1'b1, "R12", "empty enable while shifting", irq, 1);
        ie_empty = 1'b0;
        ie_done  = 1'b1;
        tick(200);
        check(irq === 1'b1, "R12", "done enable after frame", irq, 1);

        finish_run();
    end

endmodule